// File: doc/BRIEF.md
# Interrupt-Capable Eight-Pin GPIO Port

This block is an eight-pin general-purpose I/O port driven through a small register interface. Software sets each pin as an input or an output, writes output values, and reads back the actual pin levels. Every pin also has its own interrupt detector. A pin can watch for an edge or a level. It can use either polarity, and it can pass its input through a debounce filter before detection. The block brings out one request per pin and one combined request, so an integrator can wire either style into the system interrupt controller.

The register interface is a request/response stream. A request (read or write) moves across when `req_valid` and `req_ready` are both high at a rising clock edge. Writes produce no response. A read produces one response word one cycle after it is accepted, and that word stays on `rsp_data` with `rsp_valid` high until `rsp_ready` is seen high. While a response is waiting and `rsp_ready` is low, `req_ready` is low, so at most one read can be outstanding. `db_tick` is a clock enable that paces the debounce counters.

Register addresses (4-bit word address, 32-bit data, only bits 7:0 meaningful): 0 pin data, 1 direction, 2 interrupt enable, 3 detect kind (1 = edge, 0 = level), 4 polarity (1 = rising/high, 0 = falling/low), 5 debounce enable, 6 event acknowledge (write-one-to-clear, reads 0), 7 raw status, 8 enabled status. Every other address reads 0, and writes to it are ignored.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction, data, enable, kind, polarity and debounce registers read 0. Every read returns bits 31:8 as zero, and unused addresses read 0 and ignore writes.
- R2: `pin_oe` equals the direction register, and `pin_out` equals the written data register, from the cycle after the write is accepted.
- R3: Reading address 0 returns the pin levels seen on `pin_in` after a two-flop synchroniser. The read does not return the data register.
- R4: In edge mode, a rising edge (polarity 1) or a falling edge (polarity 0) of the qualified input sets that pin's latched status. The status stays set after the input returns.
- R5: In level mode, status follows the qualified input: high when polarity is 1, low when polarity is 0. It is not latched, so with reset configuration and low pins the raw status reads 0xFF.
- R6: Writing the acknowledge register clears the latched status of each pin whose written bit is 1. Pins whose bit is 0 are left alone, pins in level mode are not affected, and an edge arriving in the same cycle as the clear is kept.
- R7: The raw status register shows status before the enable mask. The enabled status register and `irq_pin` show status AND interrupt enable.
- R8: With debounce enabled, a new input level is accepted only after it has differed from the accepted level for DB_TICKS (default 4) consecutive `db_tick` cycles. Shorter pulses are ignored, and with `db_tick` low nothing is accepted.
- R9: `irq_any` is high exactly when some bit of `irq_pin` is high.
- R10: While a read response is waiting with `rsp_ready` low, `req_ready` is low and `rsp_valid`/`rsp_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_tick | input | 1 | Debounce counter clock enable |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 32 | Read response data |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| irq_pin | output | 8 | Per-pin interrupt requests |
| irq_any | output | 1 | Combined interrupt request |

## Verification
A corrupted latch bit shows up on `irq_pin` and in the raw status within one cycle. Because the bench reads status back after every acknowledge, a clear that hits the wrong pins, or that loses an edge arriving in the same cycle, shows up on the next read. A wrong synchroniser depth or debounce count shifts the time at which a request rises. The bench samples at fixed cycle counts on both sides of the expected edge, so an error of one or two cycles is caught. A response that changes under back-pressure is visible on the very next cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int NPINS = 8;
  localparam int DW    = 32;
  localparam int AW    = 4;

  typedef enum logic [AW-1:0] {
    A_DATA  = 4'd0,
    A_DIR   = 4'd1,
    A_IEN   = 4'd2,
    A_KIND  = 4'd3,
    A_POL   = 4'd4,
    A_DBEN  = 4'd5,
    A_ACK   = 4'd6,
    A_RAW   = 4'd7,
    A_MSK   = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end
  assign q = s2;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W        = 8,
  parameter int DB_TICKS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DB_TICKS - 1);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [CW-1:0] cnt;
    logic          lvl;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        lvl <= 1'b0;
      end else if (d[i] == lvl) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == LAST) begin
          lvl <= d[i];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign q[i] = lvl;
  end
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] qual,
  input  logic [W-1:0] kind,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] ack,
  output logic [W-1:0] raw
);
  logic [W-1:0] prev, latch, event_hit;

  for (genvar i = 0; i < W; i++) begin : g_det
    logic rise, fall;
    assign rise         = qual[i] & ~prev[i];
    assign fall         = ~qual[i] & prev[i];
    assign event_hit[i] = kind[i] & (pol[i] ? rise : fall);
    assign raw[i]       = kind[i] ? latch[i] : ~(qual[i] ^ pol[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev  <= '0;
      latch <= '0;
    end else begin
      prev  <= qual;
      latch <= kind & ((latch & ~ack) | event_hit);
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int DB_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          db_tick,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] irq_pin,
  output logic          irq_any
);
  logic [NPINS-1:0] data_q, dir_q, ien_q, kind_q, pol_q, dben_q;
  logic [NPINS-1:0] sync_v, db_v, qual_v, raw_v, ack_v;
  logic             acc, wr_acc, rd_acc;
  logic [NPINS-1:0] rd_byte;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign rd_acc    = acc && !req_write;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_v)
  );

  gpio_debounce #(.W(NPINS), .DB_TICKS(DB_TICKS)) u_db (
    .clk(clk), .rst_n(rst_n), .tick(db_tick), .d(sync_v), .q(db_v)
  );

  assign qual_v = (dben_q & db_v) | (~dben_q & sync_v);
  assign ack_v  = (wr_acc && req_addr == A_ACK) ? req_wdata[NPINS-1:0] : '0;

  gpio_detect #(.W(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .qual(qual_v), .kind(kind_q),
    .pol(pol_q), .ack(ack_v), .raw(raw_v)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      kind_q <= '0;
      pol_q  <= '0;
      dben_q <= '0;
    end else if (wr_acc) begin
      case (req_addr)
        A_DATA: data_q <= req_wdata[NPINS-1:0];
        A_DIR:  dir_q  <= req_wdata[NPINS-1:0];
        A_IEN:  ien_q  <= req_wdata[NPINS-1:0];
        A_KIND: kind_q <= req_wdata[NPINS-1:0];
        A_POL:  pol_q  <= req_wdata[NPINS-1:0];
        A_DBEN: dben_q <= req_wdata[NPINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (req_addr)
      A_DATA:  rd_byte = sync_v;
      A_DIR:   rd_byte = dir_q;
      A_IEN:   rd_byte = ien_q;
      A_KIND:  rd_byte = kind_q;
      A_POL:   rd_byte = pol_q;
      A_DBEN:  rd_byte = dben_q;
      A_RAW:   rd_byte = raw_v;
      A_MSK:   rd_byte = raw_v & ien_q;
      default: rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_data  <= {{(DW-NPINS){1'b0}}, rd_byte};
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;
  assign irq_pin = raw_v & ien_q;
  assign irq_any = |irq_pin;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [AW-1:0]    req_addr,
  input logic [DW-1:0]    req_wdata,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [DW-1:0]    rsp_data,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] irq_pin,
  input logic             irq_any,
  input logic [NPINS-1:0] ien_q
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_data[DW-1:NPINS] == '0);

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr == A_DIR)
      |=> pin_oe == $past(req_wdata[NPINS-1:0]));

  assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr == A_DATA)
      |=> pin_out == $past(req_wdata[NPINS-1:0]));

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pin & ~ien_q) == '0);

  assert_any_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> ien_q != '0);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_no_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind gpio_port gpio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin(irq_pin), .irq_any(irq_any),
  .ien_q(ien_q)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        db_tick = 1;
  logic        req_valid = 0, req_write = 0;
  logic [3:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready, rsp_valid;
  logic        rsp_ready = 1;
  logic [31:0] rsp_data;
  logic [7:0]  ext = 0, pin_out, pin_oe, irq_pin, pad;
  logic        irq_any;

  int tests = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;
  assign pad = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .db_tick(db_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .pin_in(pad), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_pin(irq_pin), .irq_any(irq_any)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed response
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "unexpected response", rsp_data, 0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  task automatic issue(input bit w, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    issue(1, a, d);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    issue(0, a, 0);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    // R1 reset state
    check(pin_oe == 0 && pin_out == 0, "R1 reset pins", {pin_oe, pin_out}, 0);
    check(irq_pin == 0 && irq_any == 0, "R1 reset irq", irq_pin, 0);
    rd(4'd1, 32'h0, "R1 dir reset");
    rd(4'd3, 32'h0, "R1 kind reset");
    rd(4'd7, 32'hFF, "R5 raw level-low at reset");
    rd(4'd8, 32'h0, "R7 masked at reset");
    wr(4'd15, 32'hFFFF_FFFF);
    rd(4'd15, 32'h0, "R1 unused address");
    wr(4'd6, 32'hFF);
    rd(4'd6, 32'h0, "R1 ack reads zero");

    // R2 / R3
    wr(4'd1, 32'hFFFF_FF0F);
    wr(4'd0, 32'h0000_00A5);
    check(pin_oe == 8'h0F, "R2 oe", pin_oe, 8'h0F);
    check(pin_out == 8'hA5, "R2 out", pin_out, 8'hA5);
    ext = 8'h3C;
    cyc(4);
    rd(4'd0, 32'h35, "R3 data reads pin levels");
    rd(4'd1, 32'h0F, "R1 dir upper bits zero");
    wr(4'd1, 0); wr(4'd0, 0); ext = 0; cyc(4);

    // R4 edge setup: pins1,3 edge; pin3 falling, others rising/high
    wr(4'd3, 32'h0A);
    wr(4'd4, 32'hF7);
    wr(4'd6, 32'hFF);
    wr(4'd2, 32'h0A);
    rd(4'd7, 32'h00, "R5 raw with pins low");
    ext[1] = 1; cyc(5);
    check(irq_pin == 8'h02, "R4 rising edge irq", irq_pin, 8'h02);
    check(irq_any == 1, "R9 any on pin1", irq_any, 1);
    ext[1] = 0; cyc(5);
    rd(4'd7, 32'h02, "R4 latched after input returns");
    wr(4'd6, 32'hFD);
    rd(4'd7, 32'h02, "R6 ack zero bit leaves pin");
    wr(4'd6, 32'h02);
    cyc(2);
    check(irq_pin == 0 && irq_any == 0, "R6 ack clears", irq_pin, 0);

    // falling edge pin3
    ext[3] = 1; cyc(5);
    rd(4'd7, 32'h00, "R4 rising ignored for falling pin");
    ext[3] = 0; cyc(5);
    check(irq_pin == 8'h08, "R4 falling edge irq", irq_pin, 8'h08);
    wr(4'd6, 32'h08); cyc(2);
    check(irq_pin == 0, "R6 ack pin3", irq_pin, 0);

    // R6 same-cycle edge and ack
    @(negedge clk); ext[1] = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 4'd6; req_wdata = 32'h02;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rd(4'd7, 32'h02, "R6 edge in clear cycle kept");
    ext[1] = 0; cyc(5); wr(4'd6, 32'h02);

    // R7 raw vs masked
    wr(4'd2, 32'h08);
    ext[1] = 1; cyc(5);
    rd(4'd7, 32'h02, "R7 raw shows disabled pin");
    rd(4'd8, 32'h00, "R7 masked hides disabled pin");
    check(irq_pin == 0 && irq_any == 0, "R7 irq gated", irq_pin, 0);
    wr(4'd2, 32'h0A);
    check(irq_pin == 8'h02, "R7 enable releases", irq_pin, 8'h02);
    rd(4'd8, 32'h02, "R7 masked after enable");
    ext[1] = 0; cyc(5); wr(4'd6, 32'h02);

    // R5 level pin0 (high active)
    wr(4'd2, 32'h01);
    ext[0] = 1; cyc(4);
    check(irq_pin == 8'h01, "R5 level high irq", irq_pin, 8'h01);
    wr(4'd6, 32'h01); cyc(2);
    check(irq_pin == 8'h01, "R6 ack no effect in level mode", irq_pin, 8'h01);
    ext[0] = 0; cyc(4);
    check(irq_pin == 0, "R5 level follows input", irq_pin, 0);
    wr(4'd4, 32'hF6); cyc(1);
    check(irq_pin == 8'h01, "R5 low level irq", irq_pin, 8'h01);
    wr(4'd4, 32'hF7);

    // R8 debounce pin2 (level high)
    wr(4'd5, 32'h04);
    wr(4'd2, 32'h04);
    @(negedge clk); ext[2] = 1;
    cyc(2); ext[2] = 0;
    cyc(8);
    check(irq_pin == 0, "R8 short pulse ignored", irq_pin, 0);
    ext[2] = 1;
    for (int i = 0; i < 5; i++) @(posedge clk);
    @(negedge clk);
    check(irq_pin == 0, "R8 not yet accepted", irq_pin, 0);
    @(negedge clk);
    check(irq_pin == 8'h04, "R8 accepted after DB_TICKS", irq_pin, 8'h04);
    db_tick = 0; ext[2] = 0; cyc(12);
    check(irq_pin == 8'h04, "R8 no tick no change", irq_pin, 8'h04);
    db_tick = 1; cyc(8);
    check(irq_pin == 0, "R8 release with tick", irq_pin, 0);

    // R10 back-pressure
    rsp_ready = 0;
    exp_q.push_back(32'h04); tag_q.push_back("R10 held response");
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 4'd5;
    @(negedge clk);
    req_valid = 0;
    cyc(2);
    check(rsp_valid == 1 && req_ready == 0, "R10 stall", {rsp_valid, req_ready}, 2'b10);
    check(rsp_data == 32'h04, "R10 data held", rsp_data, 32'h04);
    rsp_ready = 1;
    cyc(3);
    check(exp_q.size() == 0, "R10 response drained", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule